// File: doc/BRIEF.md
# Lowest-Priority Interrupt Arbiter

This block decides which of several destination agents accepts an interrupt that is aimed at a group of them. Each agent supplies three inputs: an 8-bit task priority, a 256-bit vector of pending requests and a 256-bit vector of interrupts in service. From these the block forms one 8-bit arbitration priority per agent. When a request strobe arrives with a vector number and a destination mask, the block grants the interrupt to the eligible agent whose arbitration priority is numerically smallest. All other agents ignore it.

A focus option can be switched on. When it is on, an eligible agent that already has the requested vector pending or in service takes the interrupt, whatever its priority. The result is registered. It appears one clock after the strobe as a one-hot grant, together with a flag that is raised when the destination mask names no agent.

Top module: `lowprio_arb`

## Requirements
- R1: The pending term of an agent is the bit index of the highest set bit of its pending vector. It is 00h when no bit is set. Only its upper nibble, called P, enters the priority.
- R2: The in-service term of an agent is the bit index of the highest set bit of its in-service vector. It is 00h when no bit is set. Only its upper nibble, called S, enters the priority.
- R3: Let T be the task priority. If T[7:4] >= P and T[7:4] > S, the arbitration priority is T. Otherwise it is {max(T[7:4], S), 4'h0}.
- R4: Only agents whose bit is set in `dest_mask` are eligible. Bit i of the mask and bit i of `grant` both refer to agent i. Among the eligible agents, the one with the lowest arbitration priority receives the grant, and exactly one grant bit is set.
- R5: When several eligible agents tie on the lowest priority, the one with the lowest index wins.
- R6: When `focus_en` is 1, an eligible agent is a focus agent if bit `req_vector` is set in its pending vector or in its in-service vector. A focus agent wins regardless of priority. If there are several focus agents, the lowest index wins. A focus agent that is not eligible is never granted.
- R7: When `focus_en` is 0, pending or in-service copies of the requested vector give no advantage. Only the priority comparison decides.
- R8: A request with an all-zero `dest_mask` produces `grant` = 0 and `no_target` = 1 in the result cycle.
- R9: `grant_valid`, `grant` and `no_target` reflect the request sampled at the previous rising clock edge. After a cycle without a strobe, all three are 0.
- R10: While `rst_n` is low, `grant_valid`, `grant` and `no_target` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_vector | input | 8 | Vector number of the request |
| dest_mask | input | N_AGENTS | Eligible agents, bit i is agent i |
| focus_en | input | 1 | Enables the focus-agent override |
| task_prio | input | 8*N_AGENTS | Task priority of agent i at bits [8i+7:8i] |
| pend_vec | input | 256*N_AGENTS | Pending requests of agent i at bits [256i+255:256i] |
| svc_vec | input | 256*N_AGENTS | In-service interrupts of agent i at bits [256i+255:256i] |
| grant_valid | output | 1 | Result valid, one cycle after the strobe |
| grant | output | N_AGENTS | One-hot winning agent |
| no_target | output | 1 | The request named no eligible agent |

## Verification
The bench first uses task priorities alone, which shows the minimum search and the ordering of ties. Pending vectors are then added with a decoy lower bit, which confirms that the highest bit sets P. In-service vectors that raise the priority to {S,0} separate the two branches of the formula. The same focus scenario is run with the override on and off, and once with the focus agent masked out, which separates the override from the plain comparison. Empty masks and random mixes of all inputs cover the rest, each compared against a behavioural model on every clock.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  localparam int VEC_W  = 8;
  localparam int NVEC   = 1 << VEC_W;
  localparam int NIB_W  = VEC_W / 2;

  // Arbitration priority from task priority and the two highest-vector terms
  function automatic logic [VEC_W-1:0] apr_calc(
    input logic [VEC_W-1:0] tpr,
    input logic [VEC_W-1:0] pend_top,
    input logic [VEC_W-1:0] svc_top
  );
    logic [NIB_W-1:0] t_hi, p_hi, s_hi, m_hi;
    t_hi = tpr[VEC_W-1 -: NIB_W];
    p_hi = pend_top[VEC_W-1 -: NIB_W];
    s_hi = svc_top[VEC_W-1 -: NIB_W];
    m_hi = (t_hi > s_hi) ? t_hi : s_hi;
    if ((t_hi >= p_hi) && (t_hi > s_hi)) return tpr;
    return {m_hi, {NIB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/lpa_prio_enc.sv
module lpa_prio_enc #(
  parameter int WIDTH  = 256,
  parameter int GROUPS = 16,
  localparam int GW  = WIDTH / GROUPS,
  localparam int IW  = $clog2(WIDTH),
  localparam int GIW = $clog2(GW),
  localparam int GSW = $clog2(GROUPS)
) (
  input  logic [WIDTH-1:0] bits,
  output logic             found,
  output logic [IW-1:0]    idx
);
  logic [GROUPS-1:0] g_any;
  logic [GIW-1:0]    g_idx [GROUPS];

  // First stage: one small encoder per group
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign g_any[g] = |bits[g*GW +: GW];
    always_comb begin
      g_idx[g] = '0;
      for (int b = 0; b < GW; b++)
        if (bits[g*GW + b]) g_idx[g] = GIW'(b);
    end
  end

  // Second stage: highest non-empty group
  always_comb begin
    found = |g_any;
    idx   = '0;
    for (int g = 0; g < GROUPS; g++)
      if (g_any[g]) idx = {GSW'(g), g_idx[g]};
  end
endmodule

// File: rtl/lpa_apr_unit.sv
module lpa_apr_unit
  import lpa_pkg::*;
#(
  parameter int ENC_GROUPS = 16
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic [NVEC-1:0]  pend,
  input  logic [NVEC-1:0]  svc,
  output logic [VEC_W-1:0] pend_top,
  output logic [VEC_W-1:0] svc_top,
  output logic [VEC_W-1:0] apr
);
  logic             p_found, s_found;
  logic [VEC_W-1:0] p_idx, s_idx;

  lpa_prio_enc #(.WIDTH(NVEC), .GROUPS(ENC_GROUPS)) u_pend_enc (
    .bits(pend), .found(p_found), .idx(p_idx));
  lpa_prio_enc #(.WIDTH(NVEC), .GROUPS(ENC_GROUPS)) u_svc_enc (
    .bits(svc), .found(s_found), .idx(s_idx));

  assign pend_top = p_found ? p_idx : '0;
  assign svc_top  = s_found ? s_idx : '0;
  assign apr      = apr_calc(tpr, pend_top, svc_top);
endmodule

// File: rtl/lpa_select.sv
module lpa_select
  import lpa_pkg::*;
#(
  parameter int N_AGENTS = 4,
  localparam int SELW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [N_AGENTS-1:0] elig,
  input  logic [N_AGENTS-1:0] focus,
  input  logic                focus_en,
  input  logic [VEC_W-1:0]    apr [N_AGENTS],
  output logic [N_AGENTS-1:0] win_oh,
  output logic                focus_taken
);
  logic [VEC_W-1:0] best;
  logic             have;
  logic [SELW-1:0]  sel;

  always_comb begin
    focus_taken = 1'b0;
    have        = 1'b0;
    best        = '1;
    sel         = '0;
    win_oh      = '0;
    // Focus override: lowest-index eligible focus agent
    for (int i = 0; i < N_AGENTS; i++)
      if (focus_en && elig[i] && focus[i] && !focus_taken) begin
        focus_taken = 1'b1;
        sel         = SELW'(i);
      end
    // Plain minimum search, strict compare keeps the lower index on ties
    if (!focus_taken)
      for (int i = 0; i < N_AGENTS; i++)
        if (elig[i] && (!have || apr[i] < best)) begin
          have = 1'b1;
          best = apr[i];
          sel  = SELW'(i);
        end
    if (focus_taken || have) win_oh[sel] = 1'b1;
  end
endmodule

// File: rtl/lowprio_arb.sv
module lowprio_arb
  import lpa_pkg::*;
#(
  parameter int N_AGENTS   = 4,
  parameter int ENC_GROUPS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [VEC_W-1:0]            req_vector,
  input  logic [N_AGENTS-1:0]         dest_mask,
  input  logic                        focus_en,
  input  logic [N_AGENTS*VEC_W-1:0]   task_prio,
  input  logic [N_AGENTS*NVEC-1:0]    pend_vec,
  input  logic [N_AGENTS*NVEC-1:0]    svc_vec,
  output logic                        grant_valid,
  output logic [N_AGENTS-1:0]         grant,
  output logic                        no_target
);
  logic [VEC_W-1:0]    apr_bus   [N_AGENTS];
  logic [VEC_W-1:0]    pend_top  [N_AGENTS];
  logic [VEC_W-1:0]    svc_top   [N_AGENTS];
  logic [N_AGENTS-1:0] focus_hit;
  logic [N_AGENTS-1:0] win_oh;
  logic                focus_taken;
  logic                mask_empty;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    lpa_apr_unit #(.ENC_GROUPS(ENC_GROUPS)) u_apr (
      .tpr      (task_prio[i*VEC_W +: VEC_W]),
      .pend     (pend_vec[i*NVEC +: NVEC]),
      .svc      (svc_vec[i*NVEC +: NVEC]),
      .pend_top (pend_top[i]),
      .svc_top  (svc_top[i]),
      .apr      (apr_bus[i])
    );
    assign focus_hit[i] = pend_vec[i*NVEC + int'(req_vector)]
                        | svc_vec[i*NVEC + int'(req_vector)];
  end

  lpa_select #(.N_AGENTS(N_AGENTS)) u_sel (
    .elig        (dest_mask),
    .focus       (focus_hit),
    .focus_en    (focus_en),
    .apr         (apr_bus),
    .win_oh      (win_oh),
    .focus_taken (focus_taken)
  );

  assign mask_empty = ~|dest_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant       <= '0;
      no_target   <= 1'b0;
    end else begin
      grant_valid <= req_valid;
      grant       <= req_valid ? win_oh : '0;
      no_target   <= req_valid && mask_empty;
    end
  end
endmodule

// File: rtl/lpa_checker.sv
module lpa_checker #(
  parameter int N_AGENTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [N_AGENTS-1:0] dest_mask,
  input logic                focus_taken,
  input logic                grant_valid,
  input logic [N_AGENTS-1:0] grant,
  input logic                no_target
);
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && |dest_mask) |=> ($countones(grant) == 1));

  p_in_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ((grant & ~$past(dest_mask)) == '0));

  p_focus_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && focus_taken) |-> (|dest_mask));

  p_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dest_mask == '0) |=> (no_target && grant == '0));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> grant_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant_valid && grant == '0 && !no_target));

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind lowprio_arb lpa_checker #(.N_AGENTS(N_AGENTS)) u_lpa_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .dest_mask   (dest_mask),
  .focus_taken (focus_taken),
  .grant_valid (grant_valid),
  .grant       (grant),
  .no_target   (no_target)
);

// File: tb/lowprio_arb_bench.sv
`timescale 1ns/1ps
module lowprio_arb_bench;
  localparam int N  = 4;
  localparam int NV = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [7:0]       req_vector = '0;
  logic [N-1:0]     dest_mask = '0;
  logic             focus_en = 1'b0;
  logic [N*8-1:0]   task_prio = '0;
  logic [N*NV-1:0]  pend_vec = '0;
  logic [N*NV-1:0]  svc_vec = '0;
  logic             grant_valid;
  logic [N-1:0]     grant;
  logic             no_target;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";
  string exp_tag = "R10";
  logic         exp_gv = 1'b0;
  logic [N-1:0] exp_gr = '0;
  logic         exp_nt = 1'b0;

  always #2.5 clk = ~clk;

  lowprio_arb #(.N_AGENTS(N)) u_lowprio_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .dest_mask(dest_mask), .focus_en(focus_en), .task_prio(task_prio),
    .pend_vec(pend_vec), .svc_vec(svc_vec), .grant_valid(grant_valid),
    .grant(grant), .no_target(no_target));

  // Reference model
  function automatic int hi_bit(input int a, input bit svc);
    for (int v = NV - 1; v >= 0; v--)
      if (svc ? svc_vec[a*NV + v] : pend_vec[a*NV + v]) return v;
    return 0;
  endfunction

  function automatic int ref_prio(input int a);
    int t, p, s;
    t = int'(task_prio[a*8 +: 8]);
    p = hi_bit(a, 1'b0) / 16;
    s = hi_bit(a, 1'b1) / 16;
    if (t / 16 >= p && t / 16 > s) return t;
    return ((t / 16 > s) ? t / 16 : s) * 16;
  endfunction

  function automatic logic [N-1:0] ref_winner();
    int win = -1;
    int best = 1000;
    logic [N-1:0] r = '0;
    if (focus_en)
      for (int a = N - 1; a >= 0; a--)
        if (dest_mask[a] && (pend_vec[a*NV + int'(req_vector)] ||
                             svc_vec[a*NV + int'(req_vector)])) win = a;
    if (win < 0)
      for (int a = 0; a < N; a++)
        if (dest_mask[a] && ref_prio(a) < best) begin
          best = ref_prio(a);
          win  = a;
        end
    if (win >= 0) r[win] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    exp_tag <= cur_req;
    if (!rst_n) begin
      exp_gv <= 1'b0; exp_gr <= '0; exp_nt <= 1'b0;
    end else begin
      exp_gv <= req_valid;
      exp_gr <= req_valid ? ref_winner() : '0;
      exp_nt <= req_valid && (dest_mask == '0);
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (!rst_n) begin
      if (grant_valid || grant != '0 || no_target) begin
        errors++;
        $display("FAIL R10: gv=%b grant=%b nt=%b, expected 0 0 0",
                 grant_valid, grant, no_target);
      end
    end else if (grant_valid !== exp_gv || grant !== exp_gr || no_target !== exp_nt) begin
      errors++;
      $display("FAIL %s: gv=%b grant=%b nt=%b, expected gv=%b grant=%b nt=%b",
               exp_tag, grant_valid, grant, no_target, exp_gv, exp_gr, exp_nt);
    end
  end

  task automatic clear_all();
    task_prio = '0; pend_vec = '0; svc_vec = '0; focus_en = 1'b0;
  endtask

  task automatic fire(input string tag, input logic [7:0] vec, input logic [N-1:0] mask);
    cur_req = tag; req_vector = vec; dest_mask = mask; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R9";
    @(negedge clk);
    // R4: task priority alone, agent 1 lowest
    task_prio = {8'h50, 8'h30, 8'h20, 8'h40};
    fire("R4", 8'h41, 4'b1111);
    // R4: mask excludes agent 1, agent 2 next lowest
    fire("R4", 8'h41, 4'b1101);
    // R1 / R3: pending 35h with decoy 12h drops agent 1 to 20h, below agent 0 at 22h
    clear_all();
    task_prio = {8'h60, 8'h60, 8'h25, 8'h22};
    pend_vec[1*NV + 8'h35] = 1'b1;
    pend_vec[1*NV + 8'h12] = 1'b1;
    fire("R1", 8'h80, 4'b1111);
    pend_vec[1*NV + 8'h35] = 1'b0;
    fire("R3", 8'h80, 4'b1111);
    // R2 / R3: in-service 61h lifts agent 0 from 10h to 60h
    clear_all();
    task_prio = {8'h70, 8'h30, 8'h70, 8'h10};
    svc_vec[0*NV + 8'h61] = 1'b1;
    fire("R2", 8'h90, 4'b1111);
    svc_vec[0*NV + 8'h61] = 1'b0;
    svc_vec[0*NV + 8'h05] = 1'b1;
    fire("R3", 8'h90, 4'b1111);
    // R5: ties
    clear_all();
    task_prio = {8'h40, 8'h40, 8'h40, 8'h40};
    fire("R5", 8'h22, 4'b1111);
    fire("R5", 8'h22, 4'b1100);
    // R6 / R7: agent 3 holds vector 70h pending, agent 2 in service
    clear_all();
    task_prio = {8'hF0, 8'hE0, 8'h10, 8'h20};
    pend_vec[3*NV + 8'h70] = 1'b1;
    svc_vec[2*NV + 8'h70]  = 1'b1;
    focus_en = 1'b1;
    fire("R6", 8'h70, 4'b1111);
    fire("R6", 8'h70, 4'b1011);
    fire("R6", 8'h70, 4'b0011);
    focus_en = 1'b0;
    fire("R7", 8'h70, 4'b1111);
    // R8: empty mask, focus on and off
    fire("R8", 8'h70, 4'b0000);
    focus_en = 1'b1;
    fire("R8", 8'h70, 4'b0000);
    // R9: back-to-back strobes
    cur_req = "R9";
    req_valid = 1'b1; dest_mask = 4'b0110; req_vector = 8'h10;
    @(negedge clk);
    dest_mask = 4'b1001;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    // Random mixes
    for (int k = 0; k < 80; k++) begin
      clear_all();
      focus_en = 1'($urandom);
      for (int a = 0; a < N; a++) begin
        task_prio[a*8 +: 8] = 8'($urandom);
        for (int j = 0; j < 3; j++) begin
          pend_vec[a*NV + int'($urandom % NV)] = 1'($urandom);
          svc_vec[a*NV + int'($urandom % NV)]  = 1'($urandom);
        end
      end
      req_vector = 8'($urandom);
      if (k % 3 == 0) pend_vec[int'($urandom % N)*NV + int'(req_vector)] = 1'b1;
      fire((k % 2 == 0) ? "R4" : "R6", req_vector, N'($urandom));
    end
    // R10: reset reasserted with a strobe pending
    cur_req = "R10";
    req_valid = 1'b1; dest_mask = 4'b1111;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule